// File: doc/BRIEF.md
# Expansion Bus Read Parity Error Logger

This block watches the read data beats of outbound reads on an external expansion bus and records the first one that comes back with bad parity. Parity checking can be turned on or off for each chip select, and only beats to an enabled chip select can raise an error. When an error is taken, the block assembles an error address from two sources. The upper bits come from the internal-bus address of the transaction and the low word-select bits come from the expansion-bus address of the failing beat. It then raises a status flag that doubles as a level interrupt request, and it pulses a drop indication so that the bus engine can discard the failing transaction.

After the first capture the logger is locked. Later bad beats, in the same burst or in later transactions, are neither recorded nor dropped. Software clears the flag by writing one to bit 0 of the status word through a small address/strobe register port. The lock stays in force until the transaction that was in flight at the moment of the clear has completed. A clear that lands in the same cycle as a fresh error wins, and that error is lost.

Top module: `parerr_capture`

## Requirements
- R1: After reset the status word reads all zeros, and `irq` and `drop` are low.
- R2: The status word is read at register offset `STAT_OFS` (default 0) and is laid out as error address in bits 31:2, a zero in bit 1 and the error flag in bit 0. Any other offset reads zero.
- R3: A captured address field equals `beat_int_hi` (internal address bits 31:5) followed by `beat_ext_lo` (expansion address bits 4:2), taken from the cycle of the capturing beat.
- R4: An error is taken only when `beat_valid`, `beat_perr` and `cs_par_en[beat_cs]` are all high in the same cycle, where `beat_cs` is the binary index of the chip select. Otherwise the flag stays clear.
- R5: While locked, further error beats leave the address field and the flag unchanged.
- R6: `drop` is high for exactly the cycle of the capturing beat, and it never goes high while the logger is locked.
- R7: A register write with bit 0 set clears the flag. Writes with bit 0 clear, and all write data in bits 31:1, have no effect.
- R8: A clear in the same cycle as a qualifying error beat leaves the flag clear, leaves the address unchanged and does not pulse `drop`.
- R9: If a transaction is still open when the flag is cleared, errors are ignored until `txn_done` closes that transaction. After that the next error is captured.
- R10: `irq` is high exactly when the status flag reads one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beat_valid | input | 1 | A read data beat is present this cycle |
| beat_perr | input | 1 | Parity check failed on this beat |
| beat_cs | input | CS_W (2) | Binary chip-select index of the beat |
| cs_par_en | input | NUM_CS (4) | Parity checking enable per chip select |
| beat_int_hi | input | ADDR_W-SPLIT (27) | Internal-bus address bits above the split |
| beat_ext_lo | input | SPLIT-2 (3) | Expansion-bus word-select address bits |
| txn_done | input | 1 | Current transaction completes this cycle |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | Access is a write |
| reg_addr | input | REG_AW (4) | Register offset |
| reg_wdata | input | ADDR_W (32) | Write data |
| reg_rdata | output | ADDR_W (32) | Read data (combinational) |
| irq | output | 1 | Level parity-error interrupt request |
| drop | output | 1 | Discard the current (first errored) transaction |

## Verification
A lock state that is wrong shows up in one of two ways. Either a second error beat overwrites the logged address, which is visible in the very next register read, or a legitimate error after release draws no `drop` pulse in its own cycle. A stuck drain state keeps the block blind after the closing `txn_done`, and that is caught by the first error beat that follows. A wrong priority between clear and capture shows in the flag and `irq` one cycle after the colliding write.

// File: rtl/parerr_pkg.sv
package parerr_pkg;
   // Lock state of the logger
   typedef enum logic [1:0] {
      LK_OPEN  = 2'd0,   // waiting for first error
      LK_HELD  = 2'd1,   // error logged, flag set
      LK_DRAIN = 2'd2    // flag cleared, waiting for open transaction to close
   } lock_st_t;
endpackage

// File: rtl/parerr_qualify.sv
module parerr_qualify #(
   parameter int NUM_CS = 4,
   parameter int CS_W   = 2
) (
   input  logic              beat_valid,
   input  logic              beat_perr,
   input  logic [CS_W-1:0]   beat_cs,
   input  logic [NUM_CS-1:0] cs_par_en,
   output logic              hit
);
   logic cs_en;

   generate
      if (NUM_CS == 1) begin : g_single
         logic unused_cs;
         assign unused_cs = ^beat_cs;
         assign cs_en     = cs_par_en[0];
      end else begin : g_multi
         always_comb begin
            cs_en = 1'b0;
            for (int i = 0; i < NUM_CS; i++)
               if (beat_cs == CS_W'(i)) cs_en = cs_par_en[i];
         end
      end
   endgenerate

   assign hit = beat_valid & beat_perr & cs_en;
endmodule

// File: rtl/parerr_lock_fsm.sv
module parerr_lock_fsm
   import parerr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     hit,
   input  logic     sw_clr,
   input  logic     beat_valid,
   input  logic     txn_done,
   output logic     capture,
   output logic     flag,
   output lock_st_t st
);
   logic in_txn;
   logic busy;

   // open transaction tracker
   always_ff @(posedge clk) begin
      if (!rst_n)          in_txn <= 1'b0;
      else if (txn_done)   in_txn <= 1'b0;
      else if (beat_valid) in_txn <= 1'b1;
   end

   assign busy    = (in_txn | beat_valid) & ~txn_done;
   // clear has priority over a colliding error
   assign capture = hit & (st == LK_OPEN) & ~sw_clr;
   assign flag    = (st == LK_HELD);

   always_ff @(posedge clk) begin
      if (!rst_n) st <= LK_OPEN;
      else begin
         unique case (st)
            LK_OPEN:  if (capture) st <= LK_HELD;
            LK_HELD:  if (sw_clr)  st <= busy ? LK_DRAIN : LK_OPEN;
            LK_DRAIN: if (txn_done) st <= LK_OPEN;
            default:  st <= LK_OPEN;
         endcase
      end
   end
endmodule

// File: rtl/parerr_addr_log.sv
module parerr_addr_log #(
   parameter int ADDR_W = 32,
   parameter int SPLIT  = 5,
   localparam int FLD_W = ADDR_W - 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    capture,
   input  logic [ADDR_W-1:SPLIT]   int_hi,
   input  logic [SPLIT-1:2]        ext_lo,
   output logic [FLD_W-1:0]        addr_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)       addr_q <= '0;
      else if (capture) addr_q <= {int_hi, ext_lo};
   end
endmodule

// File: rtl/parerr_capture.sv
module parerr_capture
   import parerr_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int SPLIT    = 5,
   parameter int NUM_CS   = 4,
   parameter int REG_AW   = 4,
   parameter int STAT_OFS = 0,
   localparam int CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int FLD_W   = ADDR_W - 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  beat_valid,
   input  logic                  beat_perr,
   input  logic [CS_W-1:0]       beat_cs,
   input  logic [NUM_CS-1:0]     cs_par_en,
   input  logic [ADDR_W-1:SPLIT] beat_int_hi,
   input  logic [SPLIT-1:2]      beat_ext_lo,
   input  logic                  txn_done,
   input  logic                  reg_sel,
   input  logic                  reg_wr,
   input  logic [REG_AW-1:0]     reg_addr,
   input  logic [ADDR_W-1:0]     reg_wdata,
   output logic [ADDR_W-1:0]     reg_rdata,
   output logic                  irq,
   output logic                  drop
);
   generate
      if (SPLIT < 3 || SPLIT >= ADDR_W) begin : g_bad_split
         $error("parerr_capture: SPLIT must lie in 3..ADDR_W-1");
      end
      if (NUM_CS < 1) begin : g_bad_cs
         $error("parerr_capture: NUM_CS must be at least 1");
      end
      if (STAT_OFS >= (1 << REG_AW)) begin : g_bad_ofs
         $error("parerr_capture: STAT_OFS does not fit REG_AW");
      end
   endgenerate

   logic             hit, capture, flag, sw_clr, ofs_hit;
   lock_st_t         st;
   logic [FLD_W-1:0] addr_q;
   logic             unused_wd;

   assign ofs_hit   = reg_sel & (reg_addr == REG_AW'(STAT_OFS));
   assign sw_clr    = ofs_hit & reg_wr & reg_wdata[0];
   assign unused_wd = ^reg_wdata[ADDR_W-1:1];

   parerr_qualify #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_qual (
      .beat_valid (beat_valid),
      .beat_perr  (beat_perr),
      .beat_cs    (beat_cs),
      .cs_par_en  (cs_par_en),
      .hit        (hit)
   );

   parerr_lock_fsm u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit        (hit),
      .sw_clr     (sw_clr),
      .beat_valid (beat_valid),
      .txn_done   (txn_done),
      .capture    (capture),
      .flag       (flag),
      .st         (st)
   );

   parerr_addr_log #(.ADDR_W(ADDR_W), .SPLIT(SPLIT)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .int_hi  (beat_int_hi),
      .ext_lo  (beat_ext_lo),
      .addr_q  (addr_q)
   );

   assign reg_rdata = ofs_hit ? {addr_q, 1'b0, flag} : '0;
   assign irq       = flag;
   assign drop      = capture;
endmodule

// File: rtl/parerr_capture_chk.sv
module parerr_capture_chk
   import parerr_pkg::*;
#(
   parameter int NUM_CS = 4,
   parameter int CS_W   = 2,
   parameter int FLD_W  = 30
) (
   input logic              clk,
   input logic              rst_n,
   input logic              beat_valid,
   input logic              beat_perr,
   input logic [CS_W-1:0]   beat_cs,
   input logic [NUM_CS-1:0] cs_par_en,
   input logic              txn_done,
   input logic              sw_clr,
   input logic              irq,
   input logic              drop,
   input logic [FLD_W-1:0]  addr_q,
   input lock_st_t          st
);
   a_r6_drop_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> irq);

   a_r6_no_drop_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (st != LK_OPEN) |-> !drop);

   a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clr |=> !irq);

   a_r5_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (st != LK_OPEN) |=> $stable(addr_q));

   a_r9_drain_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LK_DRAIN && !txn_done) |=> (st == LK_DRAIN));

   a_r4_no_set_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !(beat_valid && beat_perr && cs_par_en[beat_cs])) |=> !irq);
endmodule

bind parerr_capture parerr_capture_chk #(
   .NUM_CS (NUM_CS),
   .CS_W   (CS_W),
   .FLD_W  (FLD_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .beat_valid (beat_valid),
   .beat_perr  (beat_perr),
   .beat_cs    (beat_cs),
   .cs_par_en  (cs_par_en),
   .txn_done   (txn_done),
   .sw_clr     (sw_clr),
   .irq        (irq),
   .drop       (drop),
   .addr_q     (addr_q),
   .st         (st)
);

// File: tb/parerr_capture_test.sv
module parerr_capture_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        beat_valid = 1'b0, beat_perr = 1'b0, txn_done = 1'b0;
   logic [1:0]  beat_cs = '0;
   logic [3:0]  cs_par_en = 4'b0101;
   logic [31:5] beat_int_hi = '0;
   logic [4:2]  beat_ext_lo = '0;
   logic        reg_sel = 1'b0, reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq, drop;

   int tests = 0, fails = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   parerr_capture uut (
      .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_perr(beat_perr),
      .beat_cs(beat_cs), .cs_par_en(cs_par_en), .beat_int_hi(beat_int_hi),
      .beat_ext_lo(beat_ext_lo), .txn_done(txn_done), .reg_sel(reg_sel),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq), .drop(drop)
   );

   typedef struct packed {
      logic        v, perr;
      logic [1:0]  cs;
      logic        done, wr;
      logic [31:0] wd, ia;
      logic [4:0]  ea;
      logic        xdrop;
      logic [31:0] xword;
      logic [3:0]  rq;
   } vec_t;

   // cs_par_en = 0101: chip selects 0 and 2 checked
   localparam vec_t VEC [13] = '{
      '{1,1,2'd1,1,0,32'h0,32'h1000_0000,5'h00,0,32'h0000_0000,4'd4},  // R4 disabled cs
      '{1,0,2'd0,1,0,32'h0,32'h3000_0000,5'h1C,0,32'h0000_0000,4'd4},  // R4 no error
      '{1,1,2'd0,0,0,32'h0,32'hABCD_1220,5'h18,1,32'hABCD_1239,4'd3},  // R3 first capture
      '{1,1,2'd2,1,0,32'h0,32'h5555_5540,5'h04,0,32'hABCD_1239,4'd5},  // R5 locked
      '{0,0,2'd0,0,1,32'h1,32'h0,5'h00,0,32'hABCD_1238,4'd7},          // R7 clear idle
      '{1,1,2'd2,0,0,32'h0,32'h5555_5540,5'h0C,1,32'h5555_554D,4'd6},  // R6 capture
      '{0,0,2'd0,0,1,32'h1,32'h0,5'h00,0,32'h5555_554C,4'd9},          // R9 clear open txn
      '{1,1,2'd0,0,0,32'h0,32'h1111_1100,5'h08,0,32'h5555_554C,4'd9},  // R9 drain blind
      '{1,0,2'd0,1,0,32'h0,32'h0,5'h00,0,32'h5555_554C,4'd9},          // R9 txn closes
      '{1,1,2'd0,1,1,32'h1,32'h2222_2220,5'h1C,0,32'h5555_554C,4'd8},  // R8 collision
      '{1,1,2'd0,1,0,32'h0,32'h2222_2220,5'h1C,1,32'h2222_223D,4'd3},  // R3 recapture
      '{0,0,2'd0,0,1,32'hFFFF_FFFE,32'h0,5'h00,0,32'h2222_223D,4'd7},  // R7 zero bit0
      '{0,0,2'd0,0,1,32'h1,32'h0,5'h00,0,32'h2222_223C,4'd7}           // R7 clear
   };

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic idle_inputs();
      beat_valid = 0; beat_perr = 0; txn_done = 0; beat_cs = '0;
      beat_int_hi = '0; beat_ext_lo = '0;
      reg_sel = 0; reg_wr = 0; reg_wdata = '0; reg_addr = '0;
   endtask

   task automatic read_stat(output logic [31:0] w);
      reg_sel = 1; reg_wr = 0; reg_addr = 4'h0;
      #1 w = reg_rdata;
      reg_sel = 0;
   endtask

   initial begin
      logic [31:0] w;
      idle_inputs();
      repeat (3) @(posedge clk);
      @(negedge clk);
      read_stat(w);
      check("R1 word", w, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 drop", {31'b0, drop}, 32'h0);
      rst_n = 1;

      for (int i = 0; i < 13; i++) begin
         @(negedge clk);
         beat_valid = VEC[i].v; beat_perr = VEC[i].perr; beat_cs = VEC[i].cs;
         txn_done = VEC[i].done; beat_int_hi = VEC[i].ia[31:5]; beat_ext_lo = VEC[i].ea[4:2];
         reg_sel = VEC[i].wr; reg_wr = VEC[i].wr; reg_addr = 4'h0; reg_wdata = VEC[i].wd;
         #2 check($sformatf("R%0d drop vec%0d", VEC[i].rq, i), {31'b0, drop}, {31'b0, VEC[i].xdrop});
         @(posedge clk);
         #2 idle_inputs();
         read_stat(w);
         check($sformatf("R%0d word vec%0d", VEC[i].rq, i), w, VEC[i].xword);
         check($sformatf("R10 irq vec%0d", i), {31'b0, irq}, {31'b0, VEC[i].xword[0]});
      end

      // R2: other offset reads zero while flag set; R6 drop lasts one cycle
      @(negedge clk);
      beat_valid = 1; beat_perr = 1; beat_cs = 2'd2; txn_done = 1;
      beat_int_hi = 27'h7FF_FFFF; beat_ext_lo = 3'b101;
      @(posedge clk);
      #2 idle_inputs();
      check("R6 drop one cycle", {31'b0, drop}, 32'h0);
      read_stat(w);
      check("R2 layout bit1 zero", w, 32'hFFFF_FFF5);
      reg_sel = 1; reg_addr = 4'h1;
      #1 check("R2 other offset", reg_rdata, 32'h0);
      reg_sel = 0;

      // R1: reset mid-run clears everything
      @(negedge clk);
      rst_n = 0;
      @(posedge clk);
      #2 read_stat(w);
      check("R1 reset word", w, 32'h0);
      check("R1 reset irq", {31'b0, irq}, 32'h0);
      @(negedge clk);
      rst_n = 1;

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      finished = 1'b1;
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule